// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block ranks interrupt sources through a programmable table of priority slots. Each of the 40 slots names one source and carries a valid flag, and the slot index sets the rank: slot 0 is the most urgent. The requester presents two 32-bit banks of pending-and-enabled bits and two matching banks of routing bits. A routing bit of 1 sends a source to the fast-interrupt (FIQ) class, and a 0 sends it to the normal (IRQ) class. The block returns one 32-bit word. The low half names the winning FIQ source and the high half names the winning IRQ source, and each half has its own valid bit.

The slot table is held in registers and is loaded through a single write port. Pending, enable and routing state are produced elsewhere and arrive already combined. The result word is pure combinational logic from the inputs and the registered slot table. A slot write therefore shows in the result as soon as the capturing clock edge has passed.

Top module: `prio_resolver`

## Requirements
- R1: After reset every slot is invalid, and the result word is 0x003F003F whatever the source inputs are.
- R2: A write with `wr_en` high and `wr_idx` below 40 stores `wr_data[31]` as the slot valid flag and `wr_data[5:0]` as its source ID. All other data bits are discarded. A write with `wr_idx` of 40 or more changes no slot.
- R3: A slot takes part in ranking only when its valid flag is 1 and its source ID is below 40.
- R4: Source ID n maps to bank n/32, bit n mod 32. Bank 0 is on `act_lo`/`fiq_lo` and bank 1 is on `act_hi`/`fiq_hi`. A source is FIQ-active when its act bit and fiq bit are both 1. It is IRQ-active when its act bit is 1 and its fiq bit is 0.
- R5: When several qualifying slots name active sources of one class, the lowest-numbered slot wins.
- R6: With a FIQ winner, `win_word[15]` is 1, `win_word[14:6]` is 0 and `win_word[5:0]` is the winner's source ID.
- R7: With an IRQ winner, `win_word[31]` is 1, `win_word[30:22]` is 0 and `win_word[21:16]` is the winner's source ID.
- R8: The two halves are resolved independently. A half with no winner reads 0x003F.
- R9: When one source ID appears in several valid slots, the lowest of those slots sets its rank, and no error results.
- R10: The result follows changes on the source inputs in the same cycle. A slot write is visible in the result directly after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the slot table |
| rst_n | input | 1 | Active-low asynchronous reset, clears all slots |
| act_lo | input | 32 | Pending-and-enabled bits, sources 0..31 |
| act_hi | input | 32 | Pending-and-enabled bits, sources 32..63 (only 32..39 can win) |
| fiq_lo | input | 32 | Routing bits for sources 0..31, 1 = FIQ class |
| fiq_hi | input | 32 | Routing bits for sources 32..63, 1 = FIQ class |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot index to write |
| wr_data | input | 32 | Slot write data: bit 31 valid, bits 5:0 source ID |
| win_word | output | 32 | {IRQ valid, 9'b0, IRQ ID, FIQ valid, 9'b0, FIQ ID} |

## Verification
The only state is the slot table, so a wrong slot shows up as a wrong or missing winner in `win_word`. It appears right after the edge that wrote the slot, as soon as the named source is made active. Each slot case is therefore followed by stimulus that makes the stored slot decide the result: ranking pairs, invalid and out-of-range IDs, duplicates, and writes to indices past the table. Combinational faults in the class split or in the bank mapping appear in the same cycle as the input change.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
    // width of a source ID held in one slot
    localparam int ID_W = 6;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } slot_t;
endpackage

// File: rtl/prio_slot_table.sv
module prio_slot_table
    import prio_res_pkg::*;
#(
    parameter int NUM_SLOT = 40,
    parameter int IDX_W    = 6,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output slot_t [NUM_SLOT-1:0]       slots_o
);
    typedef struct packed {
        slot_t [NUM_SLOT-1:0] slots;
    } tab_t;

    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_SLOT);

    tab_t tab_d, tab_q;
    logic unused_bits;

    assign unused_bits = ^wr_data[DATA_W-2:ID_W];

    always_comb begin
        tab_d = tab_q;
        if (wr_en && ({1'b0, wr_idx} < LIMIT)) begin
            tab_d.slots[wr_idx].vld = wr_data[DATA_W-1];
            tab_d.slots[wr_idx].id  = wr_data[ID_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign slots_o = tab_q.slots;
endmodule

// File: rtl/prio_rank_scan.sv
module prio_rank_scan
    import prio_res_pkg::*;
#(
    parameter int NUM_SLOT = 40,
    parameter int NUM_SRC  = 40,
    parameter int VEC_W    = 64
) (
    input  slot_t [NUM_SLOT-1:0] slots_i,
    input  logic  [VEC_W-1:0]    act_i,
    output logic                 hit_o,
    output logic  [ID_W-1:0]     id_o
);
    // scan from the least urgent slot down so the lowest index is written last
    always_comb begin
        hit_o = 1'b0;
        id_o  = '1;
        for (int s = NUM_SLOT - 1; s >= 0; s--) begin
            if (slots_i[s].vld && (int'(slots_i[s].id) < NUM_SRC) &&
                act_i[slots_i[s].id]) begin
                hit_o = 1'b1;
                id_o  = slots_i[s].id;
            end
        end
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_res_pkg::*;
#(
    parameter int NUM_SLOT = 40,
    parameter int NUM_SRC  = 40,
    parameter int BANK_W   = 32,
    parameter int IDX_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] act_lo,
    input  logic [BANK_W-1:0] act_hi,
    input  logic [BANK_W-1:0] fiq_lo,
    input  logic [BANK_W-1:0] fiq_hi,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    output logic [31:0]       win_word
);
    localparam int VEC_W = 2 * BANK_W;
    localparam int PAD_W = 15 - ID_W;

    slot_t [NUM_SLOT-1:0] slots;
    logic  [VEC_W-1:0]    act_v, fiq_v, fiq_act, irq_act;
    logic                 fiq_hit, irq_hit;
    logic  [ID_W-1:0]     fiq_id, irq_id;

    prio_slot_table #(
        .NUM_SLOT (NUM_SLOT),
        .IDX_W    (IDX_W),
        .DATA_W   (32)
    ) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .slots_o (slots)
    );

    // source n sits in bank n/BANK_W at bit n mod BANK_W
    assign act_v   = {act_hi, act_lo};
    assign fiq_v   = {fiq_hi, fiq_lo};
    assign fiq_act = act_v & fiq_v;
    assign irq_act = act_v & ~fiq_v;

    prio_rank_scan #(
        .NUM_SLOT (NUM_SLOT),
        .NUM_SRC  (NUM_SRC),
        .VEC_W    (VEC_W)
    ) u_fiq_scan (
        .slots_i (slots),
        .act_i   (fiq_act),
        .hit_o   (fiq_hit),
        .id_o    (fiq_id)
    );

    prio_rank_scan #(
        .NUM_SLOT (NUM_SLOT),
        .NUM_SRC  (NUM_SRC),
        .VEC_W    (VEC_W)
    ) u_irq_scan (
        .slots_i (slots),
        .act_i   (irq_act),
        .hit_o   (irq_hit),
        .id_o    (irq_id)
    );

    assign win_word = {irq_hit, {PAD_W{1'b0}}, irq_id,
                       fiq_hit, {PAD_W{1'b0}}, fiq_id};
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
    import prio_res_pkg::*;
#(
    parameter int NUM_SLOT = 40,
    parameter int NUM_SRC  = 40,
    parameter int BANK_W   = 32,
    parameter int IDX_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [BANK_W-1:0]    act_lo,
    input logic [BANK_W-1:0]    act_hi,
    input logic [BANK_W-1:0]    fiq_lo,
    input logic [BANK_W-1:0]    fiq_hi,
    input logic                 wr_en,
    input logic [IDX_W-1:0]     wr_idx,
    input logic [31:0]          wr_data,
    input logic [31:0]          win_word,
    input slot_t [NUM_SLOT-1:0] slots
);
    logic [2*BANK_W-1:0] av, fv;
    assign av = {act_hi, act_lo};
    assign fv = {fiq_hi, fiq_lo};

    // R8
    fiq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_word[15] |-> win_word[14:0] == 15'h003F);
    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_word[31] |-> win_word[30:16] == 15'h003F);
    // R6
    fiq_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_word[15] |-> (int'(win_word[5:0]) < NUM_SRC) &&
                         av[win_word[5:0]] && fv[win_word[5:0]]);
    // R7
    irq_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_word[31] |-> (int'(win_word[21:16]) < NUM_SRC) &&
                         av[win_word[21:16]] && !fv[win_word[21:16]]);
    // R4
    no_fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((av & fv) == '0) |-> !win_word[15]);
    // R2
    wr_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) >= NUM_SLOT) |=> $stable(slots));
    // R10
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) < NUM_SLOT) |=>
        (slots[$past(wr_idx)].vld == $past(wr_data[31])) &&
        (slots[$past(wr_idx)].id == $past(wr_data[ID_W-1:0])));
endmodule

bind prio_resolver prio_resolver_chk #(
    .NUM_SLOT (NUM_SLOT),
    .NUM_SRC  (NUM_SRC),
    .BANK_W   (BANK_W),
    .IDX_W    (IDX_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_lo   (act_lo),
    .act_hi   (act_hi),
    .fiq_lo   (fiq_lo),
    .fiq_hi   (fiq_hi),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .win_word (win_word),
    .slots    (slots)
);

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] act_lo = '0, act_hi = '0, fiq_lo = '0, fiq_hi = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] win_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_resolver i_prio_resolver (
        .clk(clk), .rst_n(rst_n),
        .act_lo(act_lo), .act_hi(act_hi), .fiq_lo(fiq_lo), .fiq_hi(fiq_hi),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .win_word(win_word)
    );

    task automatic check(input string req, input logic [31:0] exp);
        n_chk++;
        if (win_word !== exp) begin
            n_bad++;
            $display("FAIL %s: win_word=%08h expected %08h", req, win_word, exp);
        end
    endtask

    task automatic wr_slot(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic drive(input logic [31:0] al, input logic [31:0] ah,
                         input logic [31:0] fl, input logic [31:0] fh);
        act_lo = al; act_hi = ah; fiq_lo = fl; fiq_hi = fh;
        #1;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 40; i++) wr_slot(i, 32'h0);
        drive(0, 0, 0, 0);
    endtask

    task automatic t_reset();
        #1;
        check("R1 reset idle", 32'h003F003F);
        drive('1, '1, 32'h0000FFFF, 0);
        check("R1 no valid slot", 32'h003F003F);
        drive(0, 0, 0, 0);
    endtask

    task automatic t_single();
        wr_slot(5, 32'h8000_0003);
        drive(32'h8, 0, 32'h8, 0);
        check("R6 fiq winner", 32'h003F8003);
        drive(32'h8, 0, 0, 0);
        check("R7 irq winner", 32'h8003003F);
        clear_all();
    endtask

    task automatic t_order();
        wr_slot(2, 32'h8000_000A);
        wr_slot(7, 32'h8000_0004);
        drive(32'h410, 0, 0, 0);
        check("R5 lower slot wins", 32'h800A003F);
        drive(32'h010, 0, 0, 0);
        check("R5 next slot after drop", 32'h8004003F);
        drive(32'h410, 0, 32'h400, 0);
        check("R8 halves independent", 32'h8004800A);
        drive(32'h410, 0, 32'h410, 0);
        check("R8 irq half idle", 32'h003F800A);
        clear_all();
    endtask

    task automatic t_qualify();
        wr_slot(0, 32'h7FFF_FFC4);
        drive(32'h10, 0, 0, 0);
        check("R2 valid bit cleared in write", 32'h003F003F);
        wr_slot(1, 32'h8000_002D);
        drive(32'h10, '1, 0, 0);
        check("R3 id 45 excluded", 32'h003F003F);
        wr_slot(1, 32'h8000_003F);
        check("R3 id 63 excluded", 32'h003F003F);
        wr_slot(3, 32'h80FF_FF02);
        drive(32'h4, 0, 0, 0);
        check("R2 upper data bits discarded", 32'h8002003F);
        clear_all();
    endtask

    task automatic t_bank1();
        wr_slot(1, 32'h8000_0023);
        drive(32'h8, 32'h8, 0, 32'h8);
        check("R4 bank1 fiq id 35", 32'h003F8023);
        drive(0, 32'h8, 32'h8, 0);
        check("R4 bank1 irq id 35", 32'h8023003F);
        wr_slot(4, 32'h8000_0027);
        drive(0, 32'h80, 0, 0);
        check("R4 bank1 id 39 last source", 32'h8027003F);
        clear_all();
    endtask

    task automatic t_dup();
        wr_slot(3, 32'h8000_0014);
        wr_slot(9, 32'h8000_0014);
        wr_slot(6, 32'h8000_0015);
        drive(32'h0030_0000, 0, 0, 0);
        check("R9 duplicate ranked by slot 3", 32'h8014003F);
        wr_slot(3, 32'h0);
        check("R9 dup left at slot 9 loses to slot 6", 32'h8015003F);
        clear_all();
    endtask

    task automatic t_oob();
        wr_slot(45, 32'h8000_0007);
        wr_slot(40, 32'h8000_0007);
        drive(32'h80, 0, 0, 0);
        check("R2 index past table ignored", 32'h003F003F);
        drive(0, 0, 0, 0);
    endtask

    task automatic t_comb();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'd12; wr_data = 32'h8000_0001;
        act_lo = 32'h2;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check("R10 write visible after edge", 32'h8001003F);
        fiq_lo = 32'h2;
        #1;
        check("R10 same-cycle input change", 32'h003F8001);
        clear_all();
    endtask

    initial begin
        #10000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_order();
        t_qualify();
        t_bank1();
        t_dup();
        t_oob();
        t_comb();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule